// File: doc/BRIEF.md
# Three-Wire Tuning Control Receiver

This block is the receiving end of a write-only three-wire serial port that sets the position of a digitally tuned component. A controller raises the enable line, clocks a byte in on the data line with the serial clock, most significant bit first, and then lowers the enable. The falling edge of the enable applies the received byte: the low five bits become the tuning step (0 to 31), the next bit chooses between active operation and low-current standby, and the two top bits are expected to be zero.

All three serial lines are asynchronous to the chip and are taken through a two-flop synchroniser into a faster system clock. Edges are found in that clock domain. A two-state frame machine follows the enable: `ST_IDLE` (enable low) moves to `ST_SELECT` on a rising enable, and `ST_SELECT` returns to `ST_IDLE` on a falling enable. That return transition is the commit. The receiver never counts bits. The shift register simply holds the last eight bits that arrived while selected, so long frames keep their tail and short frames leave earlier bits in place, shifted up.

Each commit produces a one-cycle `updated_o` pulse. A commit with either top bit set raises a sticky format-error flag. The tuning and standby fields are still applied in that case.

Top module: `tuner_ctl_slave`

## Requirements
- R1: After reset `tune_state_o` is 0, `standby_o` is 0, `fmt_err_o` is 0 and `updated_o` is 0, and the shift register holds all zeros.
- R2: While the enable is high, each rising serial-clock edge shifts the data-line level into bit 0 of the 8-bit shift register, and the older bits move up by one place. The first bit of a frame therefore ends up in bit 7 after eight clocks.
- R3: Serial-clock edges while the enable is low change nothing. A later frame with no clock edges commits the earlier word unchanged.
- R4: The outputs change only in the commit that follows a falling enable edge. Shifting in bits while selected leaves them unchanged.
- R5: When more than eight bits are clocked in one frame, only the last eight are committed.
- R6: When fewer than eight bits (n) are clocked in one frame, the committed word is the previous register shifted left by n, with the n new bits in the low positions.
- R7: On commit, `tune_state_o` takes word bits 4..0 and `standby_o` takes word bit 5 (1 = standby, 0 = active).
- R8: A commit whose word has bit 7 or bit 6 set raises `fmt_err_o`, which then stays high until reset. The fields of that word are still applied.
- R9: `updated_o` is high for exactly one system clock per commit, including a commit of a frame with no bits.
- R10: When a serial-clock rising edge and the enable falling edge are seen in the same system clock, the bit is shifted in and included in the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock, asynchronous |
| sda_i | input | 1 | Serial data, asynchronous |
| sen_i | input | 1 | Serial enable, active high, asynchronous |
| tune_state_o | output | 5 | Committed tuning step, 0 to 31 |
| standby_o | output | 1 | Committed standby control, 1 = standby |
| fmt_err_o | output | 1 | Sticky flag: a committed word had bit 7 or bit 6 set |
| updated_o | output | 1 | One-cycle pulse on each commit |

## Verification
The commit and the final shift can fall in the same system clock. This happens when the serial clock rises on the same sample as the enable falls. The bench provokes it by driving the last bit's clock rise and the enable fall at the same instant, so both pass through identical synchroniser depths. It then expects the committed fields to contain that last bit, computed from its own model of the shift. Every one of the 256 byte values is also committed through full frames and compared arithmetically against the decoded fields.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SELECT = 1'b1
    } tcs_state_e;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tcs_frame_fsm.sv
module tcs_frame_fsm
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sen_lvl,
    output logic shift_ok,
    output logic commit
);
    tcs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sen_lvl)  state_d = ST_SELECT;
            ST_SELECT: if (!sen_lvl) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shift_ok = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                shift_ok = 1'b0;
                commit   = 1'b0;
            end
            ST_SELECT: begin
                shift_ok = 1'b1;
                commit   = !sen_lvl;
            end
            default: begin
                shift_ok = 1'b0;
                commit   = 1'b0;
            end
        endcase
    end

    // R4: a commit always ends the selected state
    p_commit_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tcs_shifter.sv
module tcs_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_nxt
);
    logic [WORD_W-1:0] word_q;

    always_comb begin
        word_nxt = word_q;
        if (shift_en) word_nxt = {word_q[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_nxt;
    end

    // R2: each shift lands the incoming bit in position 0
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_q[0] == $past(bit_in)));
endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave #(
    parameter int WORD_W      = 8,
    parameter int TUNE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sen_i,
    output logic [TUNE_W-1:0] tune_state_o,
    output logic              standby_o,
    output logic              fmt_err_o,
    output logic              updated_o
);
    localparam int STBY_POS = TUNE_W;
    localparam int RSV_LSB  = TUNE_W + 1;

    logic [2:0]        sync_w;
    logic              scl_s, sda_s, sen_s, scl_prev_q, scl_rise;
    logic              shift_ok, commit;
    logic [WORD_W-1:0] word_nxt;

    tcs_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sen_i, sda_i, scl_i}),
        .sync_o  (sync_w)
    );
    assign {sen_s, sda_s, scl_s} = sync_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_prev_q <= 1'b0;
        else        scl_prev_q <= scl_s;
    end
    assign scl_rise = scl_s && !scl_prev_q;

    tcs_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sen_lvl  (sen_s),
        .shift_ok (shift_ok),
        .commit   (commit)
    );

    tcs_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_ok && scl_rise),
        .bit_in   (sda_s),
        .word_nxt (word_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_state_o <= '0;
            standby_o    <= 1'b0;
            fmt_err_o    <= 1'b0;
            updated_o    <= 1'b0;
        end else begin
            updated_o <= commit;
            if (commit) begin
                tune_state_o <= word_nxt[TUNE_W-1:0];
                standby_o    <= word_nxt[STBY_POS];
                if (|word_nxt[WORD_W-1:RSV_LSB]) fmt_err_o <= 1'b1;
            end
        end
    end

    // R4: outputs hold without a commit
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(tune_state_o) && $stable(standby_o)));
    // R7: committed fields match the word at commit
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (tune_state_o == $past(word_nxt[TUNE_W-1:0])));
    // R8: error flag is sticky
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |=> fmt_err_o);
    // R9: update pulse lasts one cycle
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        updated_o |=> !updated_o);
endmodule

// File: tb/tuner_ctl_slave_bench.sv
module tuner_ctl_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b0, sda = 1'b0, sen = 1'b0;
    logic [4:0] tune;
    logic stby, ferr, upd;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int wide = 0;
    logic upd_prev = 1'b0;
    logic [7:0] mword = 8'h00;
    logic mstate_lo;
    logic [7:0] committed = 8'h00;
    logic merr = 1'b0;

    always #2.5 clk = ~clk;

    tuner_ctl_slave u_tuner_ctl_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sen_i(sen),
        .tune_state_o(tune), .standby_o(stby), .fmt_err_o(ferr), .updated_o(upd)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (upd) pulses++;
            if (upd && upd_prev) wide++;
            upd_prev <= upd;
        end else upd_prev <= 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bits(input logic [31:0] bits, input int n, input logic sel);
        for (int i = n - 1; i >= 0; i--) begin
            sda = bits[i]; wt(2);
            scl = 1'b1;    wt(2);
            scl = 1'b0;    wt(2);
            if (sel) mword = {mword[6:0], bits[i]};
        end
    endtask

    task automatic commit_model();
        committed = mword;
        if (mword[7:6] != 2'b00) merr = 1'b1;
    endtask

    task automatic chk_outs(input string req);
        chk(req, {27'd0, tune}, {27'd0, committed[4:0]});
        chk(req, {31'd0, stby}, {31'd0, committed[5]});
        chk(req, {31'd0, ferr}, {31'd0, merr});
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        int p0;
        p0 = pulses;
        sen = 1'b1; wt(3);
        clk_bits(bits, n, 1'b1);
        sen = 1'b0; wt(8);
        commit_model();
        chk("R9 pulse count", pulses - p0, 1);
    endtask

    initial begin
        wt(3);
        chk("R1 tune", {27'd0, tune}, 0);
        chk("R1 stby", {31'd0, stby}, 0);
        chk("R1 err", {31'd0, ferr}, 0);
        chk("R1 upd", {31'd0, upd}, 0);
        rst_n = 1'b1; wt(4);

        // R2 R7 R8: every byte value, MSB first
        for (int w = 0; w < 256; w++) begin
            frame(w, 8);
            chk_outs("R7 R8 sweep");
        end

        rst_n = 1'b0; wt(2);
        mword = 8'h00; committed = 8'h00; merr = 1'b0;
        chk("R1 err after reset", {31'd0, ferr}, 0);
        chk("R1 tune after reset", {27'd0, tune}, 0);
        rst_n = 1'b1; wt(4);

        // R4: outputs unchanged while selected and shifting
        frame(32'h15, 8);
        sen = 1'b1; wt(3);
        clk_bits(32'h2A, 8, 1'b1);
        chk("R4 hold mid-frame tune", {27'd0, tune}, 32'h15);
        chk("R4 hold mid-frame stby", {31'd0, stby}, 0);
        sen = 1'b0; wt(8); commit_model();
        chk_outs("R4 commit");

        // R3: clocks with enable low ignored, then empty frame
        clk_bits(32'hFF, 8, 1'b0);
        chk("R3 no change", {27'd0, tune}, {27'd0, committed[4:0]});
        frame(0, 0);
        chk_outs("R3 R9 empty frame");

        // R5: long frame, last eight kept
        frame(32'hABC, 12);
        chk_outs("R5 long frame");
        chk("R5 tune value", {27'd0, tune}, 32'h1C);

        // R6: short frame of 3 bits
        frame(32'h1F, 8);
        frame(32'h5, 3);
        chk_outs("R6 short frame");
        chk("R6 tune value", {27'd0, tune}, 32'h1D);

        // R10: last clock rise coincides with enable fall
        begin
            int p0;
            p0 = pulses;
            sen = 1'b1; wt(3);
            clk_bits(32'h0B, 7, 1'b1);
            sda = 1'b1; wt(2);
            scl = 1'b1; sen = 1'b0; wt(2);
            scl = 1'b0; wt(8);
            mword = {mword[6:0], 1'b1};
            commit_model();
            chk_outs("R10 coincident");
            chk("R10 tune value", {27'd0, tune}, 32'h17);
            chk("R10 pulse", pulses - p0, 1);
        end

        chk("R9 pulse width", wide, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule